// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the synchronous command front end of a parallel NOR flash. It observes single-cycle bus write strobes carrying an address and a data word, recognises the multi-write unlock sequences that precede every state-changing command, and keeps track of which operating mode the memory is in. When a sequence completes it emits a one-cycle start strobe, with an operation kind, address and data, to a separate program/erase controller. That controller later reports completion or failure through two input pulses.

In identification mode the block also drives a small read multiplexer. It returns the manufacturer code, the device code, or the protection state of a block, selected by the low read-address bits and the block index. Array storage, erase timing and the erase algorithm live elsewhere. Only word-mode addressing is modelled: commands are matched on an 11-bit word address and an 8-bit command byte.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (read array), `op_start` is 0 and `id_valid` is 0.
- R2: The writes 0xAA at word address 0x555, then 0x55 at 0x2AA, then 0x90 at 0x555 enter identification mode (`mode` = 1). In that mode, `id_valid` is 1 and `id_data` depends on `rd_word_sel`: 0 gives 0x0020, 1 gives the device code (default 0x22D7), 2 gives 0x0001 if `prot_map[rd_block]` is set and 0x0000 if not, and 3 gives 0x0000. In every other mode, `id_valid` and `id_data` are 0.
- R3: In modes 0, 1 and 3, a write with data byte 0xF0 to any address returns to mode 0. This applies whether the write stands alone or ends the unlock pair. The exception is when that write is the address/data write of a program.
- R4: The unlock pair, then 0xA0 at 0x555, then a fourth write starts a program. One cycle after the fourth write, `op_start` pulses for one cycle with `op_kind` = 1, and `op_addr`/`op_data` equal that write's address and data. `mode` becomes 4.
- R5: Command matching uses only `wr_addr[10:0]` and `wr_data[7:0]`. Any values in the upper bits leave the decoding unchanged.
- R6: In modes 0, 1 and 3, a write that does not continue a valid sequence returns to mode 0 and starts nothing.
- R7: The unlock pair, then 0x20 at 0x555, enter bypass mode (`mode` = 2). In bypass mode, 0xA0 at any address followed by an address/data write starts a program, and completion returns to mode 2. The pair 0x90 then 0x00 returns to mode 0. Any other write is ignored.
- R8: In mode 4 (program) and mode 5 (chip erase), every write is ignored. `op_done` returns mode 4 to the mode that launched the program (0, 2 or 7), and returns mode 5 to mode 0.
- R9: The unlock pair, 0x80 at 0x555, the unlock pair again, then a sixth write selects an erase. If the sixth write is 0x10 at 0x555, a chip erase starts (`op_kind` = 2, `mode` = 5). If it is 0x30 at any address, a block erase starts (`op_kind` = 3, `mode` = 6), and `op_addr` carries that block address.
- R10: In mode 6, only two writes are accepted. 0xB0 issues a suspend (`op_kind` = 4, `mode` = 7). 0xF0 issues an abort (`op_kind` = 6, `mode` = 0). Other writes are ignored, and `op_done` returns to mode 0.
- R11: In mode 7, a lone 0x30 issues a resume (`op_kind` = 5, `mode` = 6). The unlock pair plus 0xA0 plus an address/data write starts a program that returns to mode 7. 0xF0 and all other writes are ignored.
- R12: A program whose address falls in a block with its `prot_map[wr_addr[19:12]]` bit set is dropped. No `op_start` is issued, the launching mode (0, 2 or 7) is restored, and no error is raised.
- R13: `op_fail` in any busy mode (4, 5 or 6) enters mode 8. In mode 8 only a 0xF0 write is accepted, and it returns to the mode that was active before the operation. That is 0, 2 or 7 for a program, and 0 for an erase.
- R14: The unlock pair, then 0x88 at 0x555, enter security-block read mode (`mode` = 3). A breaking write leaves it for mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | 20 | Word address of the write |
| wr_data | input | 16 | Data of the write |
| rd_word_sel | input | 2 | Low read-address bits selecting the identification item |
| rd_block | input | 8 | Block index of the read address |
| prot_map | input | 256 | Protection flag per block |
| op_done | input | 1 | Controller finished an operation |
| op_fail | input | 1 | Controller finished with an error |
| mode | output | 4 | Current mode code |
| op_start | output | 1 | One-cycle start strobe to the controller |
| op_kind | output | 3 | Kind of operation started |
| op_addr | output | 20 | Address handed to the controller |
| op_data | output | 16 | Data handed to the controller |
| id_valid | output | 1 | Identification data is being driven |
| id_data | output | 16 | Identification or protection value |

## Verification
Most internal faults show up one cycle after the write that exposes them. A wrong sequence step either produces a start strobe that should not exist, or omits one, or moves `mode` on the cycle after the offending write. A wrong saved return mode stays hidden until the operation completes or an error is cleared, so the bench always finishes each program and error with the completion pulse and the clearing write. A wrong identification selection shows on `id_data` in the same cycle that `rd_word_sel` or `rd_block` changes.

// File: rtl/nor_cmd_pkg.sv
`timescale 1ns/1ps
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        M_READ      = 4'd0,
        M_AUTOSEL   = 4'd1,
        M_BYPASS    = 4'd2,
        M_SECURE    = 4'd3,
        M_BUSY_PROG = 4'd4,
        M_BUSY_CHIP = 4'd5,
        M_BUSY_BLK  = 4'd6,
        M_SUSPEND   = 4'd7,
        M_ERROR     = 4'd8
    } mode_e;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_PROG    = 3'd1,
        K_CHIP    = 3'd2,
        K_BLOCK   = 3'd3,
        K_SUSPEND = 3'd4,
        K_RESUME  = 3'd5,
        K_ABORT   = 3'd6
    } kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_U1, S_U2, S_PA, S_E3, S_E4, S_E5, S_BPP, S_BPR
    } step_e;

    typedef struct packed {
        logic       unl_a;
        logic       unl_b;
        logic       at_key;
        logic [7:0] code;
    } match_t;

    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SECURE  = 8'h88;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_BLOCK   = 8'h30;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_BPEXIT  = 8'h00;
    localparam logic [7:0] KEY_A_DATA  = 8'hAA;
    localparam logic [7:0] KEY_B_DATA  = 8'h55;

endpackage

// File: rtl/nor_cmd_match.sv
`timescale 1ns/1ps
module nor_cmd_match
    import nor_cmd_pkg::*;
#(
    parameter int CMP_AW = 11
) (
    input  logic [CMP_AW-1:0] cmp_addr,
    input  logic [7:0]        cmp_byte,
    output match_t            m
);
    localparam logic [CMP_AW-1:0] KEY_A_ADDR = CMP_AW'(11'h555);
    localparam logic [CMP_AW-1:0] KEY_B_ADDR = CMP_AW'(11'h2AA);

    // Only the compare window takes part: R5
    always_comb begin
        m.at_key = (cmp_addr == KEY_A_ADDR);
        m.unl_a  = m.at_key && (cmp_byte == KEY_A_DATA);
        m.unl_b  = (cmp_addr == KEY_B_ADDR) && (cmp_byte == KEY_B_DATA);
        m.code   = cmp_byte;
    end
endmodule

// File: rtl/nor_id_mux.sv
`timescale 1ns/1ps
module nor_id_mux
    import nor_cmd_pkg::*;
#(
    parameter int          DW     = 16,
    parameter int          BLKW   = 8,
    parameter logic [15:0] MFR_ID = 16'h0020,
    parameter logic [15:0] DEV_ID = 16'h22D7,
    localparam int         NBLK   = 1 << BLKW
) (
    input  mode_e           mode,
    input  logic [1:0]      word_sel,
    input  logic [BLKW-1:0] blk,
    input  logic [NBLK-1:0] prot_map,
    output logic            id_valid,
    output logic [DW-1:0]   id_data
);
    // Identification read path: R2
    always_comb begin
        id_valid = (mode == M_AUTOSEL);
        id_data  = '0;
        if (id_valid) begin
            case (word_sel)
                2'd0:    id_data = DW'(MFR_ID);
                2'd1:    id_data = DW'(DEV_ID);
                2'd2:    id_data = DW'(prot_map[blk]);
                default: id_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/nor_cmd_fsm.sv
`timescale 1ns/1ps
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  match_t        m,
    input  logic          prot_bit,
    input  logic          op_done,
    input  logic          op_fail,
    output mode_e         mode,
    output logic          op_start,
    output kind_e         op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    typedef struct packed {
        mode_e         mode;
        mode_e         ret;
        step_e         step;
        logic          start;
        kind_e         kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } st_t;

    st_t   q, d;
    logic  prog_req;
    mode_e prog_ret;
    logic  is_rst;

    always_comb begin
        d        = q;
        d.start  = 1'b0;
        prog_req = 1'b0;
        prog_ret = M_READ;
        is_rst   = (m.code == CMD_RESET);

        case (q.mode)
            M_READ, M_AUTOSEL, M_SECURE: begin
                if (wr_en) begin
                    if (q.step == S_PA) begin
                        prog_req = 1'b1;
                        prog_ret = M_READ;
                    end else begin
                        // anything not matched below breaks the sequence: R6
                        d.mode = M_READ;
                        d.step = S_IDLE;
                        if (!is_rst) begin
                            case (q.step)
                                S_IDLE: if (m.unl_a) begin d.mode = q.mode; d.step = S_U1; end
                                S_U1:   if (m.unl_b) begin d.mode = q.mode; d.step = S_U2; end
                                S_U2: if (m.at_key) begin
                                    case (m.code)
                                        CMD_AUTOSEL: d.mode = M_AUTOSEL;
                                        CMD_BYPASS:  d.mode = M_BYPASS;
                                        CMD_SECURE:  d.mode = M_SECURE;
                                        CMD_PROG:    begin d.mode = q.mode; d.step = S_PA; end
                                        CMD_ERASE:   begin d.mode = q.mode; d.step = S_E3; end
                                        default: ;
                                    endcase
                                end
                                S_E3: if (m.unl_a) begin d.mode = q.mode; d.step = S_E4; end
                                S_E4: if (m.unl_b) begin d.mode = q.mode; d.step = S_E5; end
                                S_E5: begin
                                    if (m.at_key && m.code == CMD_CHIP) begin
                                        d.mode  = M_BUSY_CHIP;
                                        d.ret   = M_READ;
                                        d.start = 1'b1;
                                        d.kind  = K_CHIP;
                                    end else if (m.code == CMD_BLOCK) begin
                                        d.mode  = M_BUSY_BLK;
                                        d.ret   = M_READ;
                                        d.start = 1'b1;
                                        d.kind  = K_BLOCK;
                                    end
                                end
                                default: ;
                            endcase
                        end
                    end
                end
            end
            M_BYPASS: begin
                if (wr_en) begin
                    case (q.step)
                        S_BPP: begin
                            prog_req = 1'b1;
                            prog_ret = M_BYPASS;
                        end
                        S_BPR: begin
                            d.step = S_IDLE;
                            if (m.code == CMD_BPEXIT) d.mode = M_READ;
                        end
                        default: begin
                            if (m.code == CMD_PROG)         d.step = S_BPP;
                            else if (m.code == CMD_AUTOSEL) d.step = S_BPR;
                            else                            d.step = S_IDLE;
                        end
                    endcase
                end
            end
            M_BUSY_PROG: begin
                if (op_fail)      d.mode = M_ERROR;
                else if (op_done) d.mode = q.ret;
            end
            M_BUSY_CHIP: begin
                if (op_fail) begin
                    d.mode = M_ERROR;
                    d.ret  = M_READ;
                end else if (op_done) begin
                    d.mode = M_READ;
                end
            end
            M_BUSY_BLK: begin
                if (op_fail) begin
                    d.mode = M_ERROR;
                    d.ret  = M_READ;
                end else if (op_done) begin
                    d.mode = M_READ;
                end else if (wr_en) begin
                    if (is_rst) begin
                        d.mode  = M_READ;
                        d.start = 1'b1;
                        d.kind  = K_ABORT;
                    end else if (m.code == CMD_SUSPEND) begin
                        d.mode  = M_SUSPEND;
                        d.start = 1'b1;
                        d.kind  = K_SUSPEND;
                    end
                end
            end
            M_SUSPEND: begin
                if (wr_en) begin
                    d.step = S_IDLE;
                    case (q.step)
                        S_IDLE: begin
                            if (m.unl_a) begin
                                d.step = S_U1;
                            end else if (m.code == CMD_BLOCK) begin
                                d.mode  = M_BUSY_BLK;
                                d.start = 1'b1;
                                d.kind  = K_RESUME;
                            end
                        end
                        S_U1: if (m.unl_b) d.step = S_U2;
                        S_U2: if (m.at_key && m.code == CMD_PROG) d.step = S_PA;
                        S_PA: begin
                            prog_req = 1'b1;
                            prog_ret = M_SUSPEND;
                        end
                        default: ;
                    endcase
                end
            end
            M_ERROR: begin
                if (wr_en && is_rst) begin
                    d.mode = q.ret;
                    d.step = S_IDLE;
                end
            end
            default: begin
                d.mode = M_READ;
                d.step = S_IDLE;
            end
        endcase

        if (prog_req) begin
            d.step = S_IDLE;
            if (prot_bit) begin
                d.mode = prog_ret;
            end else begin
                d.mode  = M_BUSY_PROG;
                d.ret   = prog_ret;
                d.start = 1'b1;
                d.kind  = K_PROG;
            end
        end

        if (d.start) begin
            d.addr = wr_addr;
            d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode  <= M_READ;
            q.ret   <= M_READ;
            q.step  <= S_IDLE;
            q.start <= 1'b0;
            q.kind  <= K_NONE;
            q.addr  <= '0;
            q.data  <= '0;
        end else begin
            q <= d;
        end
    end

    assign mode     = q.mode;
    assign op_start = q.start;
    assign op_kind  = q.kind;
    assign op_addr  = q.addr;
    assign op_data  = q.data;

    p_busy_prog_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_BUSY_PROG && !op_done && !op_fail) |=> (q.mode == M_BUSY_PROG && !q.start));

    p_busy_chip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_BUSY_CHIP && !op_done && !op_fail) |=> (q.mode == M_BUSY_CHIP && !q.start));

    p_error_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_ERROR && !(wr_en && wr_data[7:0] == CMD_RESET)) |=> (q.mode == M_ERROR));

    p_prot_no_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && prot_bit && q.step == S_PA &&
         (q.mode == M_READ || q.mode == M_AUTOSEL || q.mode == M_SECURE)) |=> (!q.start && q.mode == M_READ));

    p_reset_to_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:0] == CMD_RESET && q.step != S_PA &&
         (q.mode == M_READ || q.mode == M_AUTOSEL || q.mode == M_SECURE)) |=> (q.mode == M_READ));

    p_suspend_no_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == M_SUSPEND && wr_en && wr_data[7:0] == CMD_RESET && q.step != S_PA) |=> (q.mode == M_SUSPEND));
endmodule

// File: rtl/nor_cmd_decoder.sv
`timescale 1ns/1ps
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int          AW      = 20,
    parameter int          DW      = 16,
    parameter int          CMP_AW  = 11,
    parameter int          BLK_LSB = 12,
    parameter logic [15:0] MFR_ID  = 16'h0020,
    parameter logic [15:0] DEV_ID  = 16'h22D7,
    localparam int         BLKW    = AW - BLK_LSB,
    localparam int         NBLK    = 1 << BLKW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [1:0]      rd_word_sel,
    input  logic [BLKW-1:0] rd_block,
    input  logic [NBLK-1:0] prot_map,
    input  logic            op_done,
    input  logic            op_fail,
    output logic [3:0]      mode,
    output logic            op_start,
    output logic [2:0]      op_kind,
    output logic [AW-1:0]   op_addr,
    output logic [DW-1:0]   op_data,
    output logic            id_valid,
    output logic [DW-1:0]   id_data
);
    match_t m;
    mode_e  mode_w;
    kind_e  kind_w;
    logic   prot_bit;

    assign prot_bit = prot_map[wr_addr[AW-1:BLK_LSB]];

    nor_cmd_match #(.CMP_AW(CMP_AW)) u_match (
        .cmp_addr (wr_addr[CMP_AW-1:0]),
        .cmp_byte (wr_data[7:0]),
        .m        (m)
    );

    nor_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .m        (m),
        .prot_bit (prot_bit),
        .op_done  (op_done),
        .op_fail  (op_fail),
        .mode     (mode_w),
        .op_start (op_start),
        .op_kind  (kind_w),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    nor_id_mux #(.DW(DW), .BLKW(BLKW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
        .mode     (mode_w),
        .word_sel (rd_word_sel),
        .blk      (rd_block),
        .prot_map (prot_map),
        .id_valid (id_valid),
        .id_data  (id_data)
    );

    assign mode    = mode_w;
    assign op_kind = kind_w;
endmodule

// File: tb/nor_cmd_decoder_test.sv
`timescale 1ns/1ps
module nor_cmd_decoder_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [19:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [1:0]   rd_word_sel = '0;
    logic [7:0]   rd_block = '0;
    logic [255:0] prot_map = '0;
    logic         op_done = 1'b0;
    logic         op_fail = 1'b0;
    logic [3:0]   mode;
    logic         op_start;
    logic [2:0]   op_kind;
    logic [19:0]  op_addr;
    logic [15:0]  op_data;
    logic         id_valid;
    logic [15:0]  id_data;

    nor_cmd_decoder uut (.*);

    always #4 clk = ~clk;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done_flag = 0;

    // behavioural reference: mode number, return mode, history of sequence words
    int em = 0, eret = 0;
    int es = 0, ek = 0;
    int ea = 0, ed = 0;
    int seq[$];

    function automatic bit is_a(int w);  return w == ((32'h555 << 8) | 32'hAA); endfunction
    function automatic bit is_b(int w);  return w == ((32'h2AA << 8) | 32'h55); endfunction

    task automatic issue(int k, int next);
        es = 1; ek = k; ea = int'(wr_addr); ed = int'(wr_data); em = next;
    endtask

    task automatic launch_prog(int r);
        seq.delete();
        if (prot_map[wr_addr[19:12]]) em = r;
        else begin issue(1, 4); eret = r; end
    endtask

    task automatic model_write();
        int w, b, ka;
        b  = int'(wr_data[7:0]);
        ka = int'(wr_addr[10:0]);
        w  = (ka << 8) | b;
        if (em == 2) begin
            if (seq.size() == 0) begin
                if (b == 'hA0 || b == 'h90) seq.push_back(b);
            end else if (seq[0] == 'hA0) launch_prog(2);
            else begin
                if (b == 0) em = 0;
                seq.delete();
            end
        end else if (em == 7) begin
            case (seq.size())
                0: if (is_a(w)) seq.push_back(w); else if (b == 'h30) issue(5, 6);
                1: if (is_b(w)) seq.push_back(w); else seq.delete();
                2: if (ka == 'h555 && b == 'hA0) seq.push_back(w); else seq.delete();
                default: launch_prog(7);
            endcase
        end else begin
            if (seq.size() == 3 && (seq[2] & 'hFF) == 'hA0) launch_prog(0);
            else if (b == 'hF0) begin em = 0; seq.delete(); end
            else begin
                bit ok;
                ok = 0;
                seq.push_back(w);
                case (seq.size())
                    1, 4: ok = is_a(w);
                    2, 5: ok = is_b(w);
                    3: if (ka == 'h555) begin
                        if (b == 'h90)      begin em = 1; seq.delete(); ok = 1; end
                        else if (b == 'h20) begin em = 2; seq.delete(); ok = 1; end
                        else if (b == 'h88) begin em = 3; seq.delete(); ok = 1; end
                        else if (b == 'hA0 || b == 'h80) ok = 1;
                    end
                    default: begin
                        if (ka == 'h555 && b == 'h10)  begin issue(2, 5); eret = 0; seq.delete(); ok = 1; end
                        else if (b == 'h30)            begin issue(3, 6); eret = 0; seq.delete(); ok = 1; end
                    end
                endcase
                if (!ok) begin em = 0; seq.delete(); end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            em = 0; eret = 0; es = 0; seq.delete();
        end else begin
            es = 0;
            case (em)
                4: if (op_fail) em = 8; else if (op_done) em = eret;
                5: if (op_fail) begin em = 8; eret = 0; end else if (op_done) em = 0;
                6: begin
                    if (op_fail) begin em = 8; eret = 0; end
                    else if (op_done) em = 0;
                    else if (wr_en && wr_data[7:0] == 8'hF0) issue(6, 0);
                    else if (wr_en && wr_data[7:0] == 8'hB0) issue(4, 7);
                end
                8: if (wr_en && wr_data[7:0] == 8'hF0) begin em = eret; seq.delete(); end
                default: if (wr_en) model_write();
            endcase
        end
    end

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done_flag) begin
            int xv, xd;
            xv = (em == 1);
            xd = 0;
            if (xv) case (rd_word_sel)
                0: xd = 'h0020;
                1: xd = 'h22D7;
                2: xd = prot_map[rd_block] ? 1 : 0;
                default: xd = 0;
            endcase
            chk("mode", int'(mode), em);
            chk("op_start", int'(op_start), es);
            if (es == 1) begin
                chk("op_kind", int'(op_kind), ek);
                chk("op_addr", int'(op_addr), ea);
                chk("op_data", int'(op_data), ed);
            end
            chk("id_valid", int'(id_valid), xv);
            chk("id_data", int'(id_data), xd);
        end
    end

    task automatic finish_up();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done_flag) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            finish_up();
        end
    end

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic unl();
        wr(20'h00555, 16'h00AA);
        wr(20'h002AA, 16'h0055);
    endtask

    task automatic pulse(input bit fail);
        @(negedge clk);
        if (fail) op_fail = 1; else op_done = 1;
        @(negedge clk);
        op_fail = 0; op_done = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        prot_map[3]   = 1'b1;
        prot_map[200] = 1'b1;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        #1;
        cur_req = "R1";
        chk("reset mode", int'(mode), 0);
        chk("reset op_start", int'(op_start), 0);
        chk("reset id_valid", int'(id_valid), 0);

        cur_req = "R2";
        unl(); wr(20'h00555, 16'h0090);
        rd_word_sel = 0; idle(2);
        rd_word_sel = 1; idle(2);
        rd_word_sel = 2; rd_block = 8'd3; idle(2);
        rd_block = 8'd4; idle(2);
        rd_block = 8'd200; idle(2);
        rd_word_sel = 3; idle(2);

        cur_req = "R3";
        wr(20'h3ABCD, 16'h00F0);
        unl(); wr(20'h00555, 16'h0090);
        unl(); wr(20'h00555, 16'h00F0);
        rd_word_sel = 0;
        wr(20'h00555, 16'h00AA); wr(20'h00123, 16'h00F0);

        cur_req = "R14";
        unl(); wr(20'h00555, 16'h0088);
        wr(20'h00010, 16'h0077);

        cur_req = "R6";
        wr(20'h00555, 16'h00AA); wr(20'h00123, 16'h0055);
        unl(); wr(20'h00555, 16'h0077);
        unl(); wr(20'h00554, 16'h0090);

        cur_req = "R5";
        wr(20'hF8555, 16'hC3AA); wr(20'h7F2AA, 16'h9955); wr(20'h11555, 16'hFF90);
        wr(20'h00000, 16'h00F0);

        cur_req = "R4";
        unl(); wr(20'h00555, 16'h00A0); wr(20'h45678, 16'hAB12);
        cur_req = "R8";
        unl(); wr(20'h00555, 16'h0090); wr(20'h00000, 16'h00F0);
        idle(2); pulse(0); idle(2);
        unl(); wr(20'h00555, 16'h0080); unl(); wr(20'h00555, 16'h0010);
        cur_req = "R9";
        wr(20'h00000, 16'h00F0); wr(20'h00555, 16'h00B0);
        pulse(0);
        unl(); wr(20'h00555, 16'h0080); unl(); wr(20'h7A123, 16'h0030);

        cur_req = "R10";
        wr(20'h00000, 16'h0055); wr(20'h00555, 16'h00AA);
        wr(20'h00000, 16'h00B0);
        cur_req = "R11";
        wr(20'h00000, 16'h00F0); wr(20'h00000, 16'h0011);
        unl(); wr(20'h00555, 16'h0030);
        wr(20'h00000, 16'h0030);
        wr(20'h00000, 16'h00B0);
        unl(); wr(20'h00555, 16'h00A0); wr(20'h12345, 16'h5A5A);
        idle(2); pulse(0);
        unl(); wr(20'h00555, 16'h00A0); wr(20'h03010, 16'h1111);
        wr(20'h00000, 16'h0030);
        cur_req = "R10";
        wr(20'h00000, 16'h00F0);
        unl(); wr(20'h00555, 16'h0080); unl(); wr(20'h20000, 16'h0030);
        pulse(0);

        cur_req = "R12";
        unl(); wr(20'h00555, 16'h00A0); wr(20'h03FFF, 16'h0000);
        unl(); wr(20'h00555, 16'h00A0); wr(20'hC8001, 16'h00F0);

        cur_req = "R7";
        unl(); wr(20'h00555, 16'h0020);
        wr(20'h00555, 16'h00F0); wr(20'h00555, 16'h00AA);
        wr(20'h00000, 16'h00A0); wr(20'h54321, 16'h00F0);
        pulse(0);
        wr(20'h00000, 16'h00A0); wr(20'h03004, 16'h2222);
        wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0055);

        cur_req = "R13";
        wr(20'h00000, 16'h00A0); wr(20'h0A0A0, 16'h3333);
        pulse(1);
        wr(20'h00555, 16'h00AA); wr(20'h00000, 16'h00B0);
        wr(20'h00000, 16'h00F0);
        cur_req = "R7";
        wr(20'h00000, 16'h0090); wr(20'h00000, 16'h0000);
        cur_req = "R13";
        unl(); wr(20'h00555, 16'h00A0); wr(20'h0B0B0, 16'h4444);
        pulse(1); wr(20'h00000, 16'h00F0);
        unl(); wr(20'h00555, 16'h0080); unl(); wr(20'h00555, 16'h0010);
        pulse(1); wr(20'h00000, 16'h0090); wr(20'h00000, 16'h00F0);
        unl(); wr(20'h00555, 16'h0080); unl(); wr(20'h66000, 16'h0030);
        wr(20'h00000, 16'h00B0);
        unl(); wr(20'h00555, 16'h00A0); wr(20'h0C0C0, 16'h5555);
        pulse(1); wr(20'h00000, 16'h00F0);
        wr(20'h00000, 16'h0030);
        pulse(1); wr(20'h00000, 16'h00F0);
        idle(3);
        finish_up();
    end
endmodule